// File: doc/BRIEF.md
# Four-Stage Streaming Floating-Point Adder

This block sums two unsigned values, each held as an integer mantissa scaled by a power of two, through a four-deep register pipeline. A fresh operand pair may enter on every clock. The stages work on different pairs at the same moment, so a long run of element-wise vector additions comes out at one result per clock once the first pair has drained through. Signs, subtraction, rounding modes and special values are not part of the format. The mantissa is unsigned. A normalized value carries its leading one in the top mantissa bit.

Each pair moves through four steps. The first orders the operands by exponent and finds the exponent gap. The second shifts the smaller mantissa right by that gap. The third adds the two mantissas with one carry bit. The fourth renormalizes the sum. A valid flag moves beside the data, so a result pops out a fixed number of clocks after its operands went in. The mantissa and exponent widths are parameters. The values used in the requirements below are the defaults: a 16-bit mantissa and an 8-bit exponent.

Top module: `fp_add_pipe`

## Requirements
- R1: While the active-low reset is asserted, and right after it is released, `out_vld` is 0 and `out_man` and `out_exp` are 0.
- R2: A pair accepted with `in_vld` high at a rising edge produces `out_vld` high exactly 4 rising edges later. Back-to-back pairs yield back-to-back results in input order.
- R3: When `in_ea` < `in_eb` the operands are swapped. Otherwise they keep their order. The result does not depend on which port carries which operand.
- R4: The smaller-exponent mantissa is shifted right by the exponent difference, and the bits shifted out are dropped with no rounding.
- R5: An exponent difference of 16 or more turns the aligned mantissa into zero. For a normalized larger operand, the result then equals that operand.
- R6: If the 16-bit mantissa sum carries out, the 17-bit sum is shifted right by one, its lowest bit is dropped, and the exponent rises by one.
- R7: Without a carry, a nonzero sum is shifted left until bit 15 is 1, and the exponent drops by the number of positions shifted.
- R8: If the leading-zero count exceeds the provisional exponent, the sum is shifted left by only the exponent value and the result exponent is 0.
- R9: A zero mantissa sum gives `out_man` = 0 and `out_exp` = 0.
- R10: An exponent increment from 255 after a carry wraps to 0 (modulo 256).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operand pair valid |
| in_ma | input | 16 | Mantissa of operand A |
| in_ea | input | 8 | Exponent of operand A |
| in_mb | input | 16 | Mantissa of operand B |
| in_eb | input | 8 | Exponent of operand B |
| out_vld | output | 1 | Result valid |
| out_man | output | 16 | Result mantissa |
| out_exp | output | 8 | Result exponent |

## Verification
The bench feeds the same operands to both ports in swapped order. A design that swaps on the wrong comparison, or gets the difference sign wrong, misaligns the mantissa, and the two results no longer agree. Directed pairs cover a gap of 16 or more, where a shifter that wraps its shift amount would bring back nonzero bits. They also cover a carry-out sum, where losing the carry halves the value, and a sum whose leading-zero count exceeds the exponent, where a normalizer without a clamp would wrap the exponent to a large value. They also cover a zero sum and the exponent wrap at 255. A long back-to-back random stream with gaps checks that every result arrives exactly four clocks after its operands, that none is lost or duplicated, and that no result appears in an idle slot.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
   localparam int FPA_MAN_W = 16;
   localparam int FPA_EXP_W = 8;
   // Alignment shifter variants
   localparam int ALIGN_DIRECT = 0;
   localparam int ALIGN_LOG    = 1;
endpackage

// File: rtl/fpa_order.sv
module fpa_order #(
   parameter int MW = 16,
   parameter int EW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vld_i,
   input  logic [MW-1:0] ma_i,
   input  logic [EW-1:0] ea_i,
   input  logic [MW-1:0] mb_i,
   input  logic [EW-1:0] eb_i,
   output logic          vld_o,
   output logic [MW-1:0] big_m_o,
   output logic [MW-1:0] sml_m_o,
   output logic [EW-1:0] exp_o,
   output logic [EW-1:0] gap_o
);
   logic swap;
   assign swap = (ea_i < eb_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o   <= 1'b0;
         big_m_o <= '0;
         sml_m_o <= '0;
         exp_o   <= '0;
         gap_o   <= '0;
      end else begin
         vld_o   <= vld_i;
         big_m_o <= swap ? mb_i : ma_i;
         sml_m_o <= swap ? ma_i : mb_i;
         exp_o   <= swap ? eb_i : ea_i;
         gap_o   <= swap ? (eb_i - ea_i) : (ea_i - eb_i);
      end
   end
endmodule

// File: rtl/fpa_align.sv
module fpa_align #(
   parameter int MW    = 16,
   parameter int EW    = 8,
   parameter int STYLE = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vld_i,
   input  logic [MW-1:0] big_m_i,
   input  logic [MW-1:0] sml_m_i,
   input  logic [EW-1:0] exp_i,
   input  logic [EW-1:0] gap_i,
   output logic          vld_o,
   output logic [MW-1:0] big_m_o,
   output logic [MW-1:0] sml_m_o,
   output logic [EW-1:0] exp_o
);
   localparam int SW = $clog2(MW);

   logic          too_far;
   logic [MW-1:0] shifted;

   assign too_far = (gap_i >= EW'(MW));

   generate
      if (STYLE == fpa_pkg::ALIGN_LOG) begin : g_log
         logic [MW-1:0] lvl [0:SW];
         assign lvl[0] = sml_m_i;
         for (genvar k = 0; k < SW; k++) begin : g_lvl
            assign lvl[k+1] = gap_i[k] ? (lvl[k] >> (1 << k)) : lvl[k];
         end
         assign shifted = lvl[SW];
      end else begin : g_direct
         assign shifted = sml_m_i >> gap_i[SW-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o   <= 1'b0;
         big_m_o <= '0;
         sml_m_o <= '0;
         exp_o   <= '0;
      end else begin
         vld_o   <= vld_i;
         big_m_o <= big_m_i;
         sml_m_o <= too_far ? '0 : shifted;
         exp_o   <= exp_i;
      end
   end
endmodule

// File: rtl/fpa_sum.sv
module fpa_sum #(
   parameter int MW = 16,
   parameter int EW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vld_i,
   input  logic [MW-1:0] big_m_i,
   input  logic [MW-1:0] sml_m_i,
   input  logic [EW-1:0] exp_i,
   output logic          vld_o,
   output logic [MW:0]   sum_o,
   output logic [EW-1:0] exp_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
         sum_o <= '0;
         exp_o <= '0;
      end else begin
         vld_o <= vld_i;
         sum_o <= {1'b0, big_m_i} + {1'b0, sml_m_i};
         exp_o <= exp_i;
      end
   end
endmodule

// File: rtl/fpa_norm.sv
module fpa_norm #(
   parameter int MW = 16,
   parameter int EW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vld_i,
   input  logic [MW:0]   sum_i,
   input  logic [EW-1:0] exp_i,
   output logic          vld_o,
   output logic [MW-1:0] man_o,
   output logic [EW-1:0] exp_o
);
   localparam int LZW = $clog2(MW + 1);

   logic [LZW-1:0] lz;
   logic [EW-1:0]  lz_e;
   logic [MW-1:0]  man_n;
   logic [EW-1:0]  exp_n;

   // leading-zero count of the low MW bits; MW when all zero
   always_comb begin
      lz = LZW'(MW);
      for (int i = 0; i < MW; i++) begin
         if (sum_i[i]) lz = LZW'(MW - 1 - i);
      end
   end

   assign lz_e = EW'(lz);

   always_comb begin
      if (sum_i[MW]) begin
         man_n = sum_i[MW:1];
         exp_n = exp_i + 1'b1;
      end else if (sum_i[MW-1:0] == '0) begin
         man_n = '0;
         exp_n = '0;
      end else if (lz_e <= exp_i) begin
         man_n = sum_i[MW-1:0] << lz;
         exp_n = exp_i - lz_e;
      end else begin
         man_n = sum_i[MW-1:0] << exp_i;
         exp_n = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
         man_o <= '0;
         exp_o <= '0;
      end else begin
         vld_o <= vld_i;
         man_o <= man_n;
         exp_o <= exp_n;
      end
   end
endmodule

// File: rtl/fp_add_pipe.sv
module fp_add_pipe #(
   parameter int MW          = fpa_pkg::FPA_MAN_W,
   parameter int EW          = fpa_pkg::FPA_EXP_W,
   parameter int ALIGN_STYLE = fpa_pkg::ALIGN_LOG
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_vld,
   input  logic [MW-1:0] in_ma,
   input  logic [EW-1:0] in_ea,
   input  logic [MW-1:0] in_mb,
   input  logic [EW-1:0] in_eb,
   output logic          out_vld,
   output logic [MW-1:0] out_man,
   output logic [EW-1:0] out_exp
);
   generate
      if (MW < 4) begin : g_bad_mw
         $error("fp_add_pipe: mantissa width must be at least 4");
      end
      if (EW < 2 || EW > 30) begin : g_bad_ew
         $error("fp_add_pipe: exponent width out of range");
      end
      if (MW >= (1 << EW)) begin : g_bad_ratio
         $error("fp_add_pipe: mantissa width must fit in the exponent range");
      end
      if (ALIGN_STYLE != fpa_pkg::ALIGN_DIRECT && ALIGN_STYLE != fpa_pkg::ALIGN_LOG) begin : g_bad_style
         $error("fp_add_pipe: unknown alignment style");
      end
   endgenerate

   logic          s1_vld, s2_vld, s3_vld;
   logic [MW-1:0] s1_big, s1_sml, s2_big, s2_sml;
   logic [EW-1:0] s1_exp, s1_gap, s2_exp, s3_exp;
   logic [MW:0]   s3_sum;

   fpa_order #(.MW(MW), .EW(EW)) u_order (
      .clk(clk), .rst_n(rst_n), .vld_i(in_vld),
      .ma_i(in_ma), .ea_i(in_ea), .mb_i(in_mb), .eb_i(in_eb),
      .vld_o(s1_vld), .big_m_o(s1_big), .sml_m_o(s1_sml),
      .exp_o(s1_exp), .gap_o(s1_gap)
   );

   fpa_align #(.MW(MW), .EW(EW), .STYLE(ALIGN_STYLE)) u_align (
      .clk(clk), .rst_n(rst_n), .vld_i(s1_vld),
      .big_m_i(s1_big), .sml_m_i(s1_sml), .exp_i(s1_exp), .gap_i(s1_gap),
      .vld_o(s2_vld), .big_m_o(s2_big), .sml_m_o(s2_sml), .exp_o(s2_exp)
   );

   fpa_sum #(.MW(MW), .EW(EW)) u_sum (
      .clk(clk), .rst_n(rst_n), .vld_i(s2_vld),
      .big_m_i(s2_big), .sml_m_i(s2_sml), .exp_i(s2_exp),
      .vld_o(s3_vld), .sum_o(s3_sum), .exp_o(s3_exp)
   );

   fpa_norm #(.MW(MW), .EW(EW)) u_norm (
      .clk(clk), .rst_n(rst_n), .vld_i(s3_vld),
      .sum_i(s3_sum), .exp_i(s3_exp),
      .vld_o(out_vld), .man_o(out_man), .exp_o(out_exp)
   );
endmodule

// File: rtl/fpa_add_chk.sv
module fpa_add_chk #(
   parameter int MW = 16,
   parameter int EW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_vld,
   input logic [EW-1:0] in_ea,
   input logic [EW-1:0] in_eb,
   input logic          out_vld,
   input logic [MW-1:0] out_man,
   input logic [EW-1:0] out_exp
);
   logic [3:0]    vld_d;
   logic [EW-1:0] emax_d [0:3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_d <= '0;
         for (int i = 0; i < 4; i++) emax_d[i] <= '0;
      end else begin
         vld_d     <= {vld_d[2:0], in_vld};
         emax_d[0] <= (in_ea > in_eb) ? in_ea : in_eb;
         for (int i = 1; i < 4; i++) emax_d[i] <= emax_d[i-1];
      end
   end

   // R1: outputs idle during reset
   assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |-> !out_vld);

   // R2: fixed four-clock latency of the valid flag
   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld == vld_d[3]);

   // R7: a nonzero exponent implies a leading one at the top bit
   assert_normalized_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && out_exp != '0) |-> out_man[MW-1]);

   // R9: zero mantissa always comes with zero exponent
   assert_zero_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && out_man == '0) |-> (out_exp == '0));

   // R6: result exponent never exceeds the larger input exponent plus one
   assert_exp_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> ({1'b0, out_exp} <= ({1'b0, emax_d[3]} + 1'b1)));
endmodule

bind fp_add_pipe fpa_add_chk #(.MW(MW), .EW(EW)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_ea(in_ea), .in_eb(in_eb),
   .out_vld(out_vld), .out_man(out_man), .out_exp(out_exp)
);

// File: tb/fp_add_pipe_bench.sv
module fp_add_pipe_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [15:0] in_ma = '0, in_mb = '0;
   logic [7:0]  in_ea = '0, in_eb = '0;
   logic        out_vld;
   logic [15:0] out_man;
   logic [7:0]  out_exp;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   logic [15:0] q_m[$];
   logic [7:0]  q_e[$];
   int          q_c[$];
   string       q_r[$];

   always #10 clk = ~clk;   // 50 MHz
   always @(posedge clk) cyc <= cyc + 1;

   fp_add_pipe u_fp_add_pipe (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
      .in_ma(in_ma), .in_ea(in_ea), .in_mb(in_mb), .in_eb(in_eb),
      .out_vld(out_vld), .out_man(out_man), .out_exp(out_exp)
   );

   // behavioural reference from the requirements
   function automatic void model(input logic [15:0] ma, input logic [7:0] ea,
                                 input logic [15:0] mb, input logic [7:0] eb,
                                 output logic [15:0] m, output logic [7:0] e);
      logic [15:0] bm, sm, al;
      logic [7:0]  be, d;
      logic [16:0] s;
      if (ea < eb) begin bm = mb; be = eb; sm = ma; d = eb - ea; end
      else         begin bm = ma; be = ea; sm = mb; d = ea - eb; end
      al = (d >= 16) ? 16'h0 : (sm >> d);
      s  = {1'b0, bm} + {1'b0, al};
      if (s[16]) begin
         m = s[16:1]; e = be + 8'd1;
      end else if (s == 0) begin
         m = 0; e = 0;
      end else begin
         e = be;
         while (!s[15] && e != 0) begin s = s << 1; e = e - 8'd1; end
         m = s[15:0];
      end
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
      total++;
      if (act !== exp_v) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
      end
   endtask

   task automatic send(input logic [15:0] ma, input logic [7:0] ea,
                       input logic [15:0] mb, input logic [7:0] eb, input string req);
      logic [15:0] m;
      logic [7:0]  e;
      @(negedge clk);
      model(ma, ea, mb, eb, m, e);
      in_vld = 1'b1; in_ma = ma; in_ea = ea; in_mb = mb; in_eb = eb;
      q_m.push_back(m); q_e.push_back(e); q_c.push_back(cyc); q_r.push_back(req);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_vld = 1'b0;
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_vld) begin
            if (q_m.size() == 0) begin
               check("R2 unexpected result", 32'd1, 32'd0);
            end else begin
               string r;
               r = q_r.pop_front();
               check({r, " man"}, {16'h0, out_man}, {16'h0, q_m.pop_front()});
               check({r, " exp"}, {24'h0, out_exp}, {24'h0, q_e.pop_front()});
               check("R2 latency", cyc - q_c.pop_front(), 32'd4);
            end
         end else if (q_c.size() != 0 && q_c[0] + 4 == cyc) begin
            check("R2 missing result", 32'd0, 32'd1);
         end
      end
   end

   initial begin
      #100000000;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 vld in reset", {31'h0, out_vld}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 vld after reset", {31'h0, out_vld}, 32'd0);
      check("R1 data after reset", {8'h0, out_man, out_exp}, 32'd0);

      send(16'h8000, 8'd10, 16'hC000, 8'd12, "R3 b larger");
      send(16'hC000, 8'd12, 16'h8000, 8'd10, "R3 swapped");
      send(16'hA000, 8'd30, 16'hA000, 8'd30, "R3 equal exps");
      send(16'h8000, 8'd5,  16'hFFFF, 8'd3,  "R4 truncating align");
      send(16'h9000, 8'd40, 16'hFFFF, 8'd20, "R5 gap 20");
      send(16'hFFFF, 8'd16, 16'hFFFF, 8'd0,  "R5 gap 16");
      send(16'h8000, 8'd15, 16'hFFFF, 8'd0,  "R4 gap 15");
      send(16'h8000, 8'd7,  16'h8001, 8'd7,  "R6 carry");
      idle(2);
      send(16'h0010, 8'd20, 16'h0001, 8'd20, "R7 leading zeros");
      send(16'h0001, 8'd3,  16'h0000, 8'd3,  "R8 underflow clamp");
      send(16'h0000, 8'd9,  16'h0000, 8'd4,  "R9 zero sum");
      send(16'h8000, 8'd255, 16'h8000, 8'd255, "R10 exponent wrap");
      idle(1);
      for (int i = 0; i < 300; i++) begin
         if (i % 37 == 5) idle(1 + i % 3);
         send(16'($urandom), 8'($urandom), 16'($urandom), 8'($urandom), "R2 stream");
      end
      idle(8);
      check("R2 queue drained", q_m.size(), 32'd0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule